// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 32-bit processor. Every lookup is compared, in parallel, against all entries. A match needs a live entry whose virtual page number and address-space identifier both equal the request. Because each entry carries its own identifier, a switch between processes needs no flush. Before any lookup, the top three address bits pick a segment. Two kernel segments map straight to physical memory with no translation, one cached and one uncached. The other two segments go through the entry array. A privilege bit blocks user code from the upper half of the address space.

A miss handler outside this block refills entries through a single write port. The handler either names a slot, or lets a free-running counter choose one at pseudo-random. Stores also get a protection check: a store to a page marked read-only, or to a page whose dirty bit is still clear, reports a modify error so software can record the first write.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so each mapped lookup misses, and `rand_slot_o` reads 0.
- R2: A lookup in a mapped segment (top bits 0xx or 11x) that matches a valid entry on both page number and identifier drives `lk_hit_o`=1, `lk_miss_o`=0 and `lk_paddr_o` = {entry physical page, 12-bit offset}, with `lk_cached_o`=1. When there is no match it drives `lk_miss_o`=1 and a zero address.
- R3: An entry loaded under one identifier never hits a lookup that carries a different identifier. Two entries with the same page number under different identifiers coexist.
- R4: Top bits 100 give an unmapped cached access and top bits 101 give an unmapped uncached access. Both set `lk_paddr_o` to the virtual address with its top three bits cleared, and neither raises hit or miss.
- R5: With `lk_user_i`=1 (user mode; 0 is kernel), any address with bit 31 set raises `lk_addr_err_o`, with no hit, no miss and a zero address. In kernel mode, the 11x segment is translated through the entries.
- R6: A store that hits an entry with read-only set or dirty clear raises `lk_mod_err_o`. A store to a dirty, writable entry does not, and a load never does.
- R7: A write with `wr_rand_i`=0 places the entry at `wr_index_i`.
- R8: The counter on `rand_slot_o` advances by one every cycle, modulo 64. A write with `wr_rand_i`=1 uses that slot. If the slot equals the one taken by the previous counter-chosen write, the write uses the next slot instead.
- R9: A write whose page number and identifier equal those of a valid entry overwrites that entry, whatever the index or random choice. `wr_slot_o` shows the slot that the write takes.
- R10: `lk_ref_o` shows the stored referenced bit of the hit entry. A hit sets the bit from the next cycle onward, and a write clears it.
- R11: A lookup in the same cycle as a write sees the contents from before the write. The write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_asid_i | input | 6 | Current address-space identifier |
| lk_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_store_i | input | 1 | Access is a store |
| lk_hit_o | output | 1 | Mapped lookup hit |
| lk_miss_o | output | 1 | Mapped lookup miss |
| lk_addr_err_o | output | 1 | User access to kernel half |
| lk_mod_err_o | output | 1 | Store to read-only or clean page |
| lk_paddr_o | output | 32 | Physical address |
| lk_cached_o | output | 1 | Access may be cached |
| lk_dirty_o | output | 1 | Dirty bit of hit entry |
| lk_ro_o | output | 1 | Read-only bit of hit entry |
| lk_ref_o | output | 1 | Referenced bit of hit entry |
| wr_en_i | input | 1 | Write an entry this cycle |
| wr_rand_i | input | 1 | 1 = counter slot, 0 = wr_index_i |
| wr_index_i | input | 6 | Explicit slot |
| wr_vpn_i | input | 20 | Virtual page number |
| wr_asid_i | input | 6 | Identifier of the entry |
| wr_ppn_i | input | 20 | Physical page number |
| wr_valid_i | input | 1 | Entry valid |
| wr_dirty_i | input | 1 | Entry dirty (writable once set) |
| wr_ro_i | input | 1 | Entry read-only |
| wr_slot_o | output | 6 | Slot the write takes |
| rand_slot_o | output | 6 | Current counter value |

## Verification
Lookup and refill can fall in the same cycle, and in one case they touch the same page. To provoke this, the bench loads an entry and, in the same cycle, looks up the page being loaded. It then expects a miss in that cycle and a hit carrying the new physical page one cycle later. A separate case tests refill against the counter. The bench waits until the counter wraps back to the slot of the previous random write, and then expects the write to move on to the next slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    SEG_USER      = 2'd0,
    SEG_KDIRECT   = 2'd1,
    SEG_KUNCACHED = 2'd2,
    SEG_KMAPPED   = 2'd3
  } seg_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic ro;
    logic refd;
  } ent_flags_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [2:0] top_i,
  output seg_e       seg_o,
  output logic       mapped_o,
  output logic       cached_o,
  output logic       kernel_o
);
  always_comb begin
    if (!top_i[2])           seg_o = SEG_USER;
    else if (top_i[1])       seg_o = SEG_KMAPPED;
    else if (top_i[0])       seg_o = SEG_KUNCACHED;
    else                     seg_o = SEG_KDIRECT;
    mapped_o = (seg_o == SEG_USER) || (seg_o == SEG_KMAPPED);
    cached_o = (seg_o != SEG_KUNCACHED);
    kernel_o = top_i[2];
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int KEY_W   = 26,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            live_i,
  input  logic [ENTRIES-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]              probe_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = live_i[g] && (keys_i[g] == probe_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  output logic [IDX_W-1:0] cnt_o,
  output logic [IDX_W-1:0] pick_o
);
  logic [IDX_W-1:0] cnt_q, last_q;
  logic             have_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] c);
    return (c == IDX_W'(ENTRIES - 1)) ? '0 : c + 1'b1;
  endfunction

  // skip the slot the previous counter-chosen write took
  assign pick_o = (have_q && cnt_q == last_q) ? step(cnt_q) : cnt_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
      have_q <= 1'b0;
    end else begin
      cnt_q <= step(cnt_q);
      if (take_i) begin
        last_q <= pick_o;
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 6,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_user_i,
  input  logic              lk_store_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_addr_err_o,
  output logic              lk_mod_err_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_cached_o,
  output logic              lk_dirty_o,
  output logic              lk_ro_o,
  output logic              lk_ref_o,
  input  logic              wr_en_i,
  input  logic              wr_rand_i,
  input  logic [IDX_W-1:0]  wr_index_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic              wr_ro_i,
  output logic [IDX_W-1:0]  wr_slot_o,
  output logic [IDX_W-1:0]  rand_slot_o
);
  localparam int KEY_W = VPN_W + ASID_W;

  logic [ENTRIES-1:0][KEY_W-1:0] key_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  ent_flags_t [ENTRIES-1:0]      flg_q;
  logic [ENTRIES-1:0]            live;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign live[g] = flg_q[g].valid;
  end

  // segment and privilege
  seg_e seg;
  logic seg_mapped, seg_cached, seg_kernel, priv_bad;

  tlb_seg_decode u_seg (
    .top_i    (lk_vaddr_i[VA_W-1 -: 3]),
    .seg_o    (seg),
    .mapped_o (seg_mapped),
    .cached_o (seg_cached),
    .kernel_o (seg_kernel)
  );

  assign priv_bad = lk_user_i && seg_kernel;

  // lookup match
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_cam (
    .live_i  (live),
    .keys_i  (key_q),
    .probe_i ({lk_vaddr_i[VA_W-1:PAGE_W], lk_asid_i}),
    .match_o (lk_match),
    .any_o   (lk_any),
    .idx_o   (lk_idx)
  );

  // duplicate check on write
  logic [ENTRIES-1:0] dup_match;
  logic               dup_any;
  logic [IDX_W-1:0]   dup_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_wr_cam (
    .live_i  (live),
    .keys_i  (key_q),
    .probe_i ({wr_vpn_i, wr_asid_i}),
    .match_o (dup_match),
    .any_o   (dup_any),
    .idx_o   (dup_idx)
  );

  // replacement counter
  logic             rand_take;
  logic [IDX_W-1:0] rand_pick;

  assign rand_take = wr_en_i && wr_rand_i && !dup_any;

  tlb_rand_ctr #(.ENTRIES(ENTRIES)) u_rand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (rand_take),
    .cnt_o  (rand_slot_o),
    .pick_o (rand_pick)
  );

  logic [IDX_W-1:0] wr_slot;
  always_comb begin
    if (dup_any)        wr_slot = dup_idx;
    else if (wr_rand_i) wr_slot = rand_pick;
    else                wr_slot = wr_index_i;
  end
  assign wr_slot_o = wr_slot;

  // lookup result
  ent_flags_t hit_flg;
  logic       ref_set;
  assign hit_flg = flg_q[lk_idx];

  always_comb begin
    lk_hit_o      = 1'b0;
    lk_miss_o     = 1'b0;
    lk_addr_err_o = 1'b0;
    lk_mod_err_o  = 1'b0;
    lk_paddr_o    = '0;
    lk_cached_o   = 1'b0;
    lk_dirty_o    = 1'b0;
    lk_ro_o       = 1'b0;
    lk_ref_o      = 1'b0;
    ref_set       = 1'b0;
    if (lk_valid_i) begin
      if (priv_bad) begin
        lk_addr_err_o = 1'b1;
      end else if (!seg_mapped) begin
        lk_paddr_o  = PA_W'(lk_vaddr_i[VA_W-4:0]);
        lk_cached_o = seg_cached;
      end else if (lk_any) begin
        lk_hit_o     = 1'b1;
        lk_paddr_o   = {ppn_q[lk_idx], lk_vaddr_i[PAGE_W-1:0]};
        lk_cached_o  = 1'b1;
        lk_dirty_o   = hit_flg.dirty;
        lk_ro_o      = hit_flg.ro;
        lk_ref_o     = hit_flg.refd;
        lk_mod_err_o = lk_store_i && (hit_flg.ro || !hit_flg.dirty);
        ref_set      = 1'b1;
      end else begin
        lk_miss_o = 1'b1;
      end
    end
  end

  // entry storage; a write wins over a referenced-bit update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      ppn_q <= '0;
      flg_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en_i && wr_slot == IDX_W'(i)) begin
          key_q[i] <= {wr_vpn_i, wr_asid_i};
          ppn_q[i] <= wr_ppn_i;
          flg_q[i] <= '{valid: wr_valid_i, dirty: wr_dirty_i, ro: wr_ro_i, refd: 1'b0};
        end else if (ref_set && lk_idx == IDX_W'(i)) begin
          flg_q[i].refd <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [VA_W-1:0]    lk_vaddr_i,
  input logic               lk_user_i,
  input logic               lk_store_i,
  input logic               lk_hit_o,
  input logic               lk_miss_o,
  input logic               lk_addr_err_o,
  input logic               lk_mod_err_o,
  input logic               lk_cached_o,
  input logic [PA_W-1:0]    lk_paddr_o,
  input logic [ENTRIES-1:0] lk_match,
  input logic               rand_take,
  input logic [IDX_W-1:0]   rand_pick
);
  logic [IDX_W-1:0] last_q;
  logic             have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (rand_take) begin
      last_q <= rand_pick;
      have_q <= 1'b1;
    end
  end

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  // R5
  user_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_user_i && lk_vaddr_i[VA_W-1])
      |-> (lk_addr_err_o && !lk_hit_o && !lk_miss_o));

  // R4
  unmapped_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_user_i && lk_vaddr_i[VA_W-1 -: 2] == 2'b10)
      |-> (!lk_hit_o && !lk_miss_o && lk_paddr_o[PA_W-1 -: 3] == 3'b000
           && lk_cached_o == !lk_vaddr_i[VA_W-3]));

  // R6
  mod_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_mod_err_o |-> (lk_hit_o && lk_store_i));

  // R8
  rand_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rand_take && have_q) |-> (rand_pick != last_q));

  // R9
  no_dup_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .ENTRIES (ENTRIES),
  .VA_W    (VA_W),
  .PA_W    (PA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_valid_i    (lk_valid_i),
  .lk_vaddr_i    (lk_vaddr_i),
  .lk_user_i     (lk_user_i),
  .lk_store_i    (lk_store_i),
  .lk_hit_o      (lk_hit_o),
  .lk_miss_o     (lk_miss_o),
  .lk_addr_err_o (lk_addr_err_o),
  .lk_mod_err_o  (lk_mod_err_o),
  .lk_cached_o   (lk_cached_o),
  .lk_paddr_o    (lk_paddr_o),
  .lk_match      (lk_match),
  .rand_take     (rand_take),
  .rand_pick     (rand_pick)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        lk_valid_i, lk_user_i, lk_store_i;
  logic [31:0] lk_vaddr_i;
  logic [5:0]  lk_asid_i;
  logic        lk_hit_o, lk_miss_o, lk_addr_err_o, lk_mod_err_o;
  logic [31:0] lk_paddr_o;
  logic        lk_cached_o, lk_dirty_o, lk_ro_o, lk_ref_o;
  logic        wr_en_i, wr_rand_i, wr_valid_i, wr_dirty_i, wr_ro_i;
  logic [5:0]  wr_index_i, wr_asid_i, wr_slot_o, rand_slot_o;
  logic [19:0] wr_vpn_i, wr_ppn_i;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_xlate uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_asid_i(lk_asid_i),
    .lk_user_i(lk_user_i), .lk_store_i(lk_store_i),
    .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_addr_err_o(lk_addr_err_o),
    .lk_mod_err_o(lk_mod_err_o), .lk_paddr_o(lk_paddr_o), .lk_cached_o(lk_cached_o),
    .lk_dirty_o(lk_dirty_o), .lk_ro_o(lk_ro_o), .lk_ref_o(lk_ref_o),
    .wr_en_i(wr_en_i), .wr_rand_i(wr_rand_i), .wr_index_i(wr_index_i),
    .wr_vpn_i(wr_vpn_i), .wr_asid_i(wr_asid_i), .wr_ppn_i(wr_ppn_i),
    .wr_valid_i(wr_valid_i), .wr_dirty_i(wr_dirty_i), .wr_ro_i(wr_ro_i),
    .wr_slot_o(wr_slot_o), .rand_slot_o(rand_slot_o)
  );

  typedef struct packed {
    logic        user;
    logic        store;
    logic [5:0]  asid;
    logic [31:0] va;
    logic        hit;
    logic        miss;
    logic        aerr;
    logic        merr;
    logic        cached;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 6'd3, 32'h00400ABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h12345ABC},
    '{1'b1, 1'b0, 6'd4, 32'h00400ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000},
    '{1'b1, 1'b1, 6'd3, 32'h00401010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0ABCD010},
    '{1'b1, 1'b1, 6'd3, 32'h00402FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00777FFF},
    '{1'b1, 1'b1, 6'd3, 32'h00400004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h12345004},
    '{1'b0, 1'b0, 6'd3, 32'h80001234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00001234},
    '{1'b0, 1'b1, 6'd3, 32'hA0001234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00001234},
    '{1'b1, 1'b0, 6'd3, 32'h80001234, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000},
    '{1'b0, 1'b0, 6'd3, 32'hC0000010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00055010},
    '{1'b1, 1'b0, 6'd3, 32'hC0000010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000},
    '{1'b0, 1'b0, 6'd3, 32'h00403000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000},
    '{1'b1, 1'b0, 6'd3, 32'h00401010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0ABCD010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid,
                      input logic user, input logic store);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_vaddr_i = va; lk_asid_i = asid;
    lk_user_i = user; lk_store_i = store;
    #1;
  endtask

  task automatic put(input logic rnd, input logic [5:0] idx, input logic [19:0] vpn,
                     input logic [5:0] asid, input logic [19:0] ppn,
                     input logic dirty, input logic ro);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_rand_i = rnd; wr_index_i = idx; wr_vpn_i = vpn;
    wr_asid_i = asid; wr_ppn_i = ppn; wr_valid_i = 1'b1;
    wr_dirty_i = dirty; wr_ro_i = ro;
  endtask

  task automatic put_end;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] r0, last;
    rst_ni = 1'b0;
    lk_valid_i = 0; lk_vaddr_i = 0; lk_asid_i = 0; lk_user_i = 0; lk_store_i = 0;
    wr_en_i = 0; wr_rand_i = 0; wr_index_i = 0; wr_vpn_i = 0; wr_asid_i = 0;
    wr_ppn_i = 0; wr_valid_i = 0; wr_dirty_i = 0; wr_ro_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rand_slot after reset", 32'(rand_slot_o), 32'd0);
    look(32'h00400000, 6'd3, 1'b0, 1'b0);
    chk("R1 miss after reset", 32'(lk_miss_o), 32'd1);
    chk("R1 no hit after reset", 32'(lk_hit_o), 32'd0);
    r0 = rand_slot_o;
    @(negedge clk_i); #1;
    chk("R8 counter step", 32'(rand_slot_o), 32'(6'(r0 + 6'd1)));

    // R7 indexed loads
    put(1'b0, 6'd5,  20'h00400, 6'd3, 20'h12345, 1'b1, 1'b0);
    #1 chk("R7 indexed slot", 32'(wr_slot_o), 32'd5);
    put_end();
    put(1'b0, 6'd9,  20'h00401, 6'd3, 20'h0ABCD, 1'b0, 1'b0); put_end();
    put(1'b0, 6'd10, 20'h00402, 6'd3, 20'h00777, 1'b1, 1'b1); put_end();
    put(1'b0, 6'd12, 20'hC0000, 6'd3, 20'h00055, 1'b1, 1'b0); put_end();

    // R10 referenced bit
    look(32'h00402000, 6'd3, 1'b0, 1'b0);
    chk("R10 ref clear after write", 32'(lk_ref_o), 32'd0);
    look(32'h00402000, 6'd3, 1'b0, 1'b0);
    chk("R10 ref set after hit", 32'(lk_ref_o), 32'd1);
    chk("R6 load no mod err", 32'(lk_mod_err_o), 32'd0);
    put(1'b0, 6'd40, 20'h00402, 6'd3, 20'h00777, 1'b1, 1'b1);
    #1 chk("R9 rewrite lands on existing slot", 32'(wr_slot_o), 32'd10);
    put_end();
    look(32'h00402000, 6'd3, 1'b0, 1'b0);
    chk("R10 ref cleared by rewrite", 32'(lk_ref_o), 32'd0);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      look(VECS[i].va, VECS[i].asid, VECS[i].user, VECS[i].store);
      chk($sformatf("R2 hit v%0d", i),      32'(lk_hit_o),      32'(VECS[i].hit));
      chk($sformatf("R3 miss v%0d", i),     32'(lk_miss_o),     32'(VECS[i].miss));
      chk($sformatf("R5 addr_err v%0d", i), 32'(lk_addr_err_o), 32'(VECS[i].aerr));
      chk($sformatf("R6 mod_err v%0d", i),  32'(lk_mod_err_o),  32'(VECS[i].merr));
      chk($sformatf("R4 cached v%0d", i),   32'(lk_cached_o),   32'(VECS[i].cached));
      chk($sformatf("R2 paddr v%0d", i),    lk_paddr_o,         VECS[i].pa);
    end

    // R9 duplicate goes to existing slot, R3 identifiers coexist
    put(1'b0, 6'd20, 20'h00400, 6'd3, 20'h11111, 1'b1, 1'b0);
    #1 chk("R9 dup slot", 32'(wr_slot_o), 32'd5);
    put_end();
    put(1'b0, 6'd20, 20'h00400, 6'd4, 20'h22222, 1'b1, 1'b0);
    #1 chk("R9 other asid not dup", 32'(wr_slot_o), 32'd20);
    put_end();
    look(32'h00400ABC, 6'd3, 1'b1, 1'b0);
    chk("R9 dup overwrite paddr", lk_paddr_o, 32'h11111ABC);
    look(32'h00400ABC, 6'd4, 1'b1, 1'b0);
    chk("R3 second asid paddr", lk_paddr_o, 32'h22222ABC);

    // R11 lookup and write together
    put(1'b0, 6'd30, 20'h00500, 6'd3, 20'h00999, 1'b1, 1'b0);
    lk_valid_i = 1'b1; lk_vaddr_i = 32'h00500000; lk_asid_i = 6'd3;
    lk_user_i = 1'b0; lk_store_i = 1'b0;
    #1 chk("R11 same-cycle miss", 32'(lk_miss_o), 32'd1);
    put_end();
    @(negedge clk_i); #1;
    chk("R11 next-cycle hit", 32'(lk_hit_o), 32'd1);
    chk("R11 next-cycle paddr", lk_paddr_o, 32'h00999000);

    // R8 random replacement and no-repeat
    put(1'b1, 6'd0, 20'h00600, 6'd3, 20'h00600, 1'b1, 1'b0);
    #1;
    last = rand_slot_o;
    chk("R8 random slot from counter", 32'(wr_slot_o), 32'(last));
    put_end();
    for (int k = 0; k < 70; k++) begin
      @(negedge clk_i); #1;
      if (rand_slot_o == last) break;
    end
    chk("R8 counter wrapped to previous slot", 32'(rand_slot_o), 32'(last));
    wr_en_i = 1'b1; wr_rand_i = 1'b1; wr_vpn_i = 20'h00601; wr_asid_i = 6'd3;
    wr_ppn_i = 20'h00601; wr_valid_i = 1'b1; wr_dirty_i = 1'b1; wr_ro_i = 1'b0;
    #1 chk("R8 repeat skipped", 32'(wr_slot_o), 32'(6'(last + 6'd1)));
    put_end();
    look(32'h00601000, 6'd3, 1'b0, 1'b0);
    chk("R8 second random entry", lk_paddr_o, 32'h00601000);
    look(32'h00600000, 6'd3, 1'b0, 1'b0);
    chk("R8 first random entry kept", lk_paddr_o, 32'h00600000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule